// File: doc/BRIEF.md
# Wide Hierarchical Lookahead Adder

This block adds two wide unsigned operands and a single carry-in in one combinational pass. The result is a sum as wide as the operands and a carry-out. It is meant as the adder core of a datapath, where a carry chain that ripples through the word would set the cycle time.

The operand bits are split into nibble slices. Each slice produces a group propagate term and a group generate term, and does not pass its carry on to the next slice. Combiner nodes sit above the slices. Each node merges up to four child propagate/generate pairs and sends a resolved carry back down to each child. The nodes repeat level by level until a single root node remains, and the root receives the external carry-in. When the slice count is not a power of four, the nodes at the edge of a level simply have fewer children. The number of levels is derived from the width at elaboration.

Top module: `wide_cla_adder`

## Requirements
- R1: For all operand values, {carry_out, sum} equals the unsigned value of op_a + op_b + carry_in, at the default width of 128 bits.
- R2: The width parameter must be a multiple of 4 and at least 8, and elaboration stops on any other value. A 256-bit instance behaves exactly as R1 states at its own width.
- R3: The carry into each 4-bit slice is supplied by the lookahead tree and equals the carry produced by all lower operand bits plus carry_in. A carry chain that spans every slice resolves in the same pass.
- R4: carry_out is 1 exactly when the whole word generates a carry, or when the whole word propagates and carry_in is 1. For example, all-ones plus all-ones with carry_in 1 gives an all-ones sum with carry_out 1.
- R5: An all-ones operand plus zero with carry_in 1 gives an all-zero sum and carry_out 1.
- R6: When op_a is the bitwise inverse of op_b and carry_in is 0, the sum is all ones and carry_out is 0. With carry_in 1 the sum is all zeros and carry_out is 1.
- R7: Two zero operands give a sum equal to carry_in in bit 0, zeros in all other bits, and carry_out 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the total |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
Zero operands show that the adder creates no stray carries and that carry_in reaches bit 0. All-ones plus one and all-ones plus carry-in send a carry through every slice and every level of the tree, so a wrong or missing carry link at any node shows up in the sum. Complementary patterns (alternating 0101 against 1010, and a value against its inverse) make every bit propagate and no bit generate. This separates a correct propagate path from one that treats propagate as generate. A single carry across a nibble boundary and random operands at both 128 and 256 bits cover the general case, including a width whose slice count is not a power of four.

// File: rtl/wide_cla_pkg.sv
package wide_cla_pkg;

   // number of nodes on tree level k (level 0 holds the nibble slices)
   function automatic int lvl_cnt(input int nslice, input int k);
      int n;
      n = nslice;
      for (int i = 0; i < k; i++) n = (n + 3) / 4;
      return n;
   endfunction

   // index of the first node of level k in the flat node vectors
   function automatic int lvl_off(input int nslice, input int k);
      int o;
      o = 0;
      for (int i = 0; i < k; i++) o += lvl_cnt(nslice, i);
      return o;
   endfunction

   // combiner levels needed above the slices to reach one root
   function automatic int num_lvls(input int nslice);
      int n;
      int l;
      n = nslice;
      l = 0;
      while (n > 1) begin
         n = (n + 3) / 4;
         l++;
      end
      return l;
   endfunction

   // carry after the first n of four positions, in sum-of-products form
   function automatic logic la_carry(input logic [3:0] p, input logic [3:0] g,
                                     input logic cin, input int n);
      logic res;
      logic prod;
      res = 1'b0;
      for (int m = 0; m < 4; m++) begin
         if (m < n) begin
            prod = g[m];
            for (int q = 0; q < 4; q++)
               if (q > m && q < n) prod = prod & p[q];
            res = res | prod;
         end
      end
      prod = cin;
      for (int q = 0; q < 4; q++)
         if (q < n) prod = prod & p[q];
      return res | prod;
   endfunction

endpackage

// File: rtl/cla_slice4.sv
module cla_slice4
   import wide_cla_pkg::*;
(
   input  logic [3:0] sl_a,
   input  logic [3:0] sl_b,
   input  logic       sl_cin,
   output logic [3:0] sl_sum,
   output logic       sl_prop,
   output logic       sl_gen
);
   logic [3:0] bp;
   logic [3:0] bg;
   logic [3:0] bc;

   assign bp = sl_a ^ sl_b;
   assign bg = sl_a & sl_b;

   for (genvar i = 0; i < 4; i++) begin : g_bit
      assign bc[i] = la_carry(bp, bg, sl_cin, i);
   end

   assign sl_sum  = bp ^ bc;
   assign sl_prop = &bp;
   assign sl_gen  = la_carry(bp, bg, 1'b0, 4);
endmodule

// File: rtl/cla_node.sv
module cla_node
   import wide_cla_pkg::*;
#(
   parameter int NCH = 4
) (
   input  logic [NCH-1:0] ch_prop,
   input  logic [NCH-1:0] ch_gen,
   input  logic           nd_cin,
   output logic [NCH-1:0] ch_cin,
   output logic           nd_prop,
   output logic           nd_gen
);
   logic [3:0] pp;
   logic [3:0] gg;

   if (NCH < 1 || NCH > 4) begin : g_bad_nch
      $error("cla_node: NCH must lie in 1..4");
   end

   for (genvar i = 0; i < 4; i++) begin : g_pad
      if (i < NCH) begin : g_real
         assign pp[i] = ch_prop[i];
         assign gg[i] = ch_gen[i];
      end else begin : g_fill
         assign pp[i] = 1'b1;
         assign gg[i] = 1'b0;
      end
   end

   for (genvar i = 0; i < NCH; i++) begin : g_cout
      assign ch_cin[i] = la_carry(pp, gg, nd_cin, i);
   end

   assign nd_prop = &pp;
   assign nd_gen  = la_carry(pp, gg, 1'b0, 4);
endmodule

// File: rtl/wide_cla_adder.sv
module wide_cla_adder
   import wide_cla_pkg::*;
#(
   parameter int WIDTH = 128
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             carry_in,
   output logic [WIDTH-1:0] sum,
   output logic             carry_out
);
   localparam int NSLICE = WIDTH / 4;
   localparam int NLVL   = num_lvls(NSLICE);
   localparam int NTOT   = lvl_off(NSLICE, NLVL + 1);
   localparam int ROOT   = NTOT - 1;

   if (WIDTH % 4 != 0 || WIDTH < 8) begin : g_bad_width
      $error("wide_cla_adder: WIDTH must be a multiple of 4 and at least 8");
   end

   logic [NTOT-1:0] node_p;
   logic [NTOT-1:0] node_g;
   logic [NTOT-1:0] node_c;

   for (genvar j = 0; j < NSLICE; j++) begin : g_slice
      cla_slice4 u_slice (
         .sl_a    (op_a[4*j +: 4]),
         .sl_b    (op_b[4*j +: 4]),
         .sl_cin  (node_c[j]),
         .sl_sum  (sum[4*j +: 4]),
         .sl_prop (node_p[j]),
         .sl_gen  (node_g[j])
      );
   end

   for (genvar k = 1; k <= NLVL; k++) begin : g_lvl
      localparam int NBELOW = lvl_cnt(NSLICE, k - 1);
      localparam int NHERE  = lvl_cnt(NSLICE, k);
      for (genvar j = 0; j < NHERE; j++) begin : g_node
         localparam int CH0  = lvl_off(NSLICE, k - 1) + 4 * j;
         localparam int NCH  = (NBELOW - 4 * j) < 4 ? (NBELOW - 4 * j) : 4;
         localparam int SELF = lvl_off(NSLICE, k) + j;
         cla_node #(.NCH(NCH)) u_node (
            .ch_prop (node_p[CH0 +: NCH]),
            .ch_gen  (node_g[CH0 +: NCH]),
            .nd_cin  (node_c[SELF]),
            .ch_cin  (node_c[CH0 +: NCH]),
            .nd_prop (node_p[SELF]),
            .nd_gen  (node_g[SELF])
         );
      end
   end

   assign node_c[ROOT] = carry_in;
   assign carry_out    = node_g[ROOT] | (node_p[ROOT] & carry_in);
endmodule

// File: rtl/wide_cla_adder_chk.sv
module wide_cla_adder_chk #(
   parameter int WIDTH  = 128,
   parameter int NSLICE = WIDTH / 4
) (
   input logic [WIDTH-1:0]  op_a,
   input logic [WIDTH-1:0]  op_b,
   input logic              carry_in,
   input logic [WIDTH-1:0]  sum,
   input logic              carry_out,
   input logic [NSLICE-1:0] slice_cin
);
   logic [WIDTH:0] total;
   logic [NSLICE-1:0] prefix_c;

   always_comb begin
      total = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
      for (int j = 0; j < NSLICE; j++) begin
         logic [WIDTH:0] mask;
         logic [WIDTH:0] part;
         mask = ({{WIDTH{1'b0}}, 1'b1} << (4 * j)) - 1'b1;
         part = ({1'b0, op_a} & mask) + ({1'b0, op_b} & mask)
                + {{WIDTH{1'b0}}, carry_in};
         prefix_c[j] = part[4 * j];
      end
   end

   always_comb begin
      AST_SUM_EXACT: assert ({carry_out, sum} == total) else $error("sum mismatch"); // R1
      AST_SLICE_CARRY: assert (slice_cin == prefix_c) else $error("slice carry mismatch"); // R3
      if (op_a == ~op_b) begin
         AST_COMPL_FILL: assert (sum == {WIDTH{~carry_in}} && carry_out == carry_in) else $error("complement case"); // R6
      end
      if (op_a == '0 && op_b == '0) begin
         AST_ZERO_PASS: assert (sum == {{(WIDTH-1){1'b0}}, carry_in} && !carry_out) else $error("zero case"); // R7
      end
   end
endmodule

bind wide_cla_adder wide_cla_adder_chk #(.WIDTH(WIDTH)) u_chk (
   .op_a      (op_a),
   .op_b      (op_b),
   .carry_in  (carry_in),
   .sum       (sum),
   .carry_out (carry_out),
   .slice_cin (node_c[NSLICE-1:0])
);

// File: tb/wide_cla_adder_tb.sv
`timescale 1ns/1ps
module wide_cla_adder_tb;
   localparam int WN = 128;
   localparam int WW = 256;

   typedef struct {
      logic [WN:0] exp_n;
      logic [WW:0] exp_w;
      string       tag;
   } item_t;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [WN-1:0] a_n, b_n, s_n;
   logic [WW-1:0] a_w, b_w, s_w;
   logic          ci, co_n, co_w;
   item_t         sb_q[$];
   int            n_checks = 0;
   int            n_errors = 0;
   bit            done = 1'b0;

   wide_cla_adder u_dut (
      .op_a(a_n), .op_b(b_n), .carry_in(ci), .sum(s_n), .carry_out(co_n)
   );

   wide_cla_adder #(.WIDTH(WW)) u_dut_w (
      .op_a(a_w), .op_b(b_w), .carry_in(ci), .sum(s_w), .carry_out(co_w)
   );

   task automatic drive(input logic [WW-1:0] a, input logic [WW-1:0] b,
                        input logic c, input string tag);
      item_t it;
      @(negedge clk);
      a_w = a;
      b_w = b;
      a_n = a[WN-1:0];
      b_n = b[WN-1:0];
      ci  = c;
      it.exp_n = {1'b0, a[WN-1:0]} + {1'b0, b[WN-1:0]} + {{WN{1'b0}}, c};
      it.exp_w = {1'b0, a} + {1'b0, b} + {{WW{1'b0}}, c};
      it.tag   = tag;
      sb_q.push_back(it);
   endtask

   // monitor: inputs settle at the falling edge, compared at the rising edge
   always @(posedge clk) begin
      if (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         n_checks++;
         if ({co_n, s_n} != it.exp_n) begin
            n_errors++;
            $display("FAIL %s (w128): got %h expected %h", it.tag, {co_n, s_n}, it.exp_n);
         end
         n_checks++;
         if ({co_w, s_w} != it.exp_w) begin
            n_errors++;
            $display("FAIL %s (w256, R2): got %h expected %h", it.tag, {co_w, s_w}, it.exp_w);
         end
      end
   end

   function automatic logic [WW-1:0] rnd256();
      logic [WW-1:0] r;
      for (int i = 0; i < WW / 32; i++) r[32*i +: 32] = $urandom;
      return r;
   endfunction

   initial begin
      a_n = '0; b_n = '0; a_w = '0; b_w = '0; ci = 1'b0;
      drive('0, '0, 1'b0, "R7 zero");
      drive('0, '0, 1'b1, "R7 zero+cin");
      drive({WW{1'b1}}, 256'd1, 1'b0, "R3 ones+1");
      drive({WW{1'b1}}, '0, 1'b1, "R5 ones+cin");
      drive({64{4'h5}}, {64{4'hA}}, 1'b0, "R6 alt");
      drive({64{4'h5}}, {64{4'hA}}, 1'b1, "R6 alt+cin");
      drive({WW{1'b1}}, {WW{1'b1}}, 1'b1, "R4 max+max+cin");
      drive({WW{1'b1}}, {WW{1'b1}}, 1'b0, "R4 max+max");
      drive(256'h0F, 256'h01, 1'b0, "R3 nibble edge");
      drive(256'hFFFF, 256'h0, 1'b1, "R3 four slices");
      begin
         logic [WW-1:0] r;
         r = rnd256();
         drive(r, ~r, 1'b1, "R6 inverse");
      end
      for (int i = 0; i < 60; i++) drive(rnd256(), rnd256(), i[0], "R1 random");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end
endmodule